// File: doc/BRIEF.md
# Synchronized Clock Stop Gate

This block gates a group of clock outputs derived from one source clock. An active-low stop request arrives asynchronously. The block passes it through a synchronizer clocked by the source clock. It then halts the gated outputs at logic 0 and later restarts them without a runt pulse. Outputs that are marked free-running ignore the request. Every output also has its own enable bit, and there is a common tristate control that drops all output enables.

Gating decisions are registered on the falling edge of the source clock. Each output is the AND of the source clock and its gate flop, so a gate can only change while the clock is low. This makes every emitted high phase full width. A minimum-run window protects the clocked logic downstream. Once the outputs start, a stop request waits until the outputs have produced at least `MIN_RUN` high pulses. If the request is still asserted at that point, it takes effect.

The same block covers the processor group (deep window) and the bus group (short window) by choosing `MIN_RUN` and `SYNC_STAGES`.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst` is high at a rising edge, every `clk_out` bit is low and every `clk_oe` bit is 0. After reset the controller is in the running state and its window count starts from zero.
- R2: `stop_n` is sampled through `SYNC_STAGES` flops on rising edges of `clk_src`. Take the first rising edge that samples `stop_n` low with the run window already satisfied. Gated outputs emit exactly `SYNC_STAGES`+1 more high pulses starting at that edge, then stay low. With the default of 2 stages, that is 3 pulses, fewer than 4.
- R3: `clk_out` bits are never high while `clk_src` is low. A stopped output is held at 0.
- R4: Take the first rising edge that samples `stop_n` high while stopped. The first high pulse appears at rising edge number `SYNC_STAGES`+2, counting that edge as number 1. The pulse is high for the full high phase of `clk_src`.
- R5: Once running, a gated output emits at least `MIN_RUN` high pulses before stopping. A stop request that arrives inside this window is held and applied when the window ends.
- R6: Outputs whose `FREE_MASK` bit is 1 keep toggling regardless of `stop_n`. Default `FREE_MASK` is 4'b1000, so bit 3 is free-running.
- R7: An `en_mask` bit of 0, sampled at a falling edge of `clk_src`, holds that output low from the next rising edge on. This applies to free-running outputs too.
- R8: `clk_oe` is all zeros one rising edge after `tristate` is sampled high, and all ones one edge after it is sampled low (outside reset). `tristate` does not change `clk_out`.
- R9: Each restart begins a new run window counted from zero. A request that returns one cycle after a restart still yields exactly `MIN_RUN` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock that is gated |
| rst | input | 1 | Synchronous active-high reset |
| stop_n | input | 1 | Asynchronous active-low stop request |
| en_mask | input | N_OUT | Per-output enable, 1 = allowed to toggle |
| tristate | input | 1 | 1 = drive all output enables low |
| clk_out | output | N_OUT | Gated clock outputs |
| clk_oe | output | N_OUT | Output-buffer enables for the gated clocks |

## Verification
The bench aims at stop requests that arrive inside the minimum-run window. A design that ignored the window would yield far fewer than `MIN_RUN` pulses, and one that dropped a pending request would never stop. It also measures exact stop and restart latency in pulses. An off-by-one synchronizer or gate placement shows up as an extra or missing pulse, and a gate updated on the rising edge shows up as a shortened first high phase. A one-cycle release of the request right after a restart exposes a run counter that is not cleared on restart. Disabled and free-running lanes are counted separately, so a lane that ignores its enable or wrongly obeys the stop request is caught.

// File: rtl/csg_pkg.sv
package csg_pkg;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } run_state_e;

    typedef struct packed {
        logic enable;
        logic free;
        logic run;
    } lane_cmd_t;

    function automatic logic lane_open(input lane_cmd_t cmd);
        return cmd.enable & (cmd.free | cmd.run);
    endfunction

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/csg_sync.sv
module csg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_src,
    input  logic rst,
    input  logic async_n,
    output logic stop_req
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_src) begin
                if (rst) chain_q <= 1'b1;
                else     chain_q <= async_n;
            end
        end else begin : g_multi
            always_ff @(posedge clk_src) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], async_n};
            end
        end
    endgenerate

    assign stop_req = ~chain_q[STAGES-1];
endmodule

// File: rtl/csg_ctrl.sv
module csg_ctrl
    import csg_pkg::*;
#(
    parameter int MIN_RUN = 100,
    parameter int CNT_W   = 7
) (
    input  logic             clk_src,
    input  logic             rst,
    input  logic             stop_req,
    output logic             run_en,
    output logic [CNT_W-1:0] run_cnt
);
    localparam logic [CNT_W-1:0] THRESH = CNT_W'(MIN_RUN - 1);

    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            ST_RUN: begin
                if (stop_req && (cnt_q >= THRESH)) begin
                    state_d = ST_HALT;
                end else if (cnt_q < THRESH) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                if (!stop_req) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk_src) begin
        if (rst) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign run_en  = (state_q == ST_RUN);
    assign run_cnt = cnt_q;
endmodule

// File: rtl/csg_lane.sv
module csg_lane
    import csg_pkg::*;
#(
    parameter bit FREE = 1'b0
) (
    input  logic clk_src,
    input  logic rst,
    input  logic enable,
    input  logic run_en,
    output logic gate_q,
    output logic clk_out
);
    lane_cmd_t cmd;

    always_comb begin
        cmd.enable = enable;
        cmd.free   = FREE;
        cmd.run    = run_en;
    end

    always_ff @(negedge clk_src) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= lane_open(cmd);
    end

    assign clk_out = clk_src & gate_q;
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
    parameter int               N_OUT       = 4,
    parameter int               SYNC_STAGES = 2,
    parameter int               MIN_RUN     = 100,
    parameter logic [N_OUT-1:0] FREE_MASK   = 4'b1000
) (
    input  logic             clk_src,
    input  logic             rst,
    input  logic             stop_n,
    input  logic [N_OUT-1:0] en_mask,
    input  logic             tristate,
    output logic [N_OUT-1:0] clk_out,
    output logic [N_OUT-1:0] clk_oe
);
    localparam int CNT_W = csg_pkg::cnt_width(MIN_RUN);

    logic             stop_req;
    logic             run_en;
    logic [CNT_W-1:0] run_cnt;
    logic [N_OUT-1:0] gate_q;
    logic [N_OUT-1:0] oe_q;

    csg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_src  (clk_src),
        .rst      (rst),
        .async_n  (stop_n),
        .stop_req (stop_req)
    );

    csg_ctrl #(.MIN_RUN(MIN_RUN), .CNT_W(CNT_W)) u_ctrl (
        .clk_src  (clk_src),
        .rst      (rst),
        .stop_req (stop_req),
        .run_en   (run_en),
        .run_cnt  (run_cnt)
    );

    generate
        for (genvar i = 0; i < N_OUT; i++) begin : g_lane
            csg_lane #(.FREE(FREE_MASK[i])) u_lane (
                .clk_src (clk_src),
                .rst     (rst),
                .enable  (en_mask[i]),
                .run_en  (run_en),
                .gate_q  (gate_q[i]),
                .clk_out (clk_out[i])
            );
        end
    endgenerate

    always_ff @(posedge clk_src) begin
        if (rst) oe_q <= '0;
        else     oe_q <= {N_OUT{~tristate}};
    end

    assign clk_oe = oe_q;
endmodule

// File: rtl/csg_check.sv
module csg_check #(
    parameter int               N_OUT     = 4,
    parameter int               MIN_RUN   = 100,
    parameter logic [N_OUT-1:0] FREE_MASK = 4'b1000,
    parameter int               CNT_W     = 7
) (
    input logic             clk_src,
    input logic             rst,
    input logic             stop_req,
    input logic             run_en,
    input logic [CNT_W-1:0] run_cnt,
    input logic [N_OUT-1:0] gate_q,
    input logic             tristate,
    input logic [N_OUT-1:0] clk_oe
);
    localparam logic [CNT_W-1:0] THRESH = CNT_W'(MIN_RUN - 1);

    // R3: while halted, every non-free gate is closed
    p_halt_gates_closed_r3: assert property (@(posedge clk_src) disable iff (rst)
        !run_en |-> ((gate_q & ~FREE_MASK) == '0));

    // R5: leaving the running state only after the window is complete
    p_min_run_r5: assert property (@(posedge clk_src) disable iff (rst)
        $fell(run_en) |-> ($past(run_cnt) >= THRESH));

    // R2: a synchronized request with the window done halts on the next edge
    p_stop_taken_r2: assert property (@(posedge clk_src) disable iff (rst)
        (run_en && stop_req && (run_cnt >= THRESH)) |=> !run_en);

    // R4 / R9: a released request restarts with a fresh window
    p_restart_r4: assert property (@(posedge clk_src) disable iff (rst)
        (!run_en && !stop_req) |=> (run_en && (run_cnt == '0)));

    // R8: tristate drops all enables one edge later
    p_oe_off_r8: assert property (@(posedge clk_src) disable iff (rst)
        tristate |=> (clk_oe == '0));

    // R8: enables return one edge after tristate clears
    p_oe_on_r8: assert property (@(posedge clk_src) disable iff (rst)
        !tristate |=> (clk_oe == '1));
endmodule

bind clk_stop_gate csg_check #(
    .N_OUT     (N_OUT),
    .MIN_RUN   (MIN_RUN),
    .FREE_MASK (FREE_MASK),
    .CNT_W     (CNT_W)
) u_check (
    .clk_src  (clk_src),
    .rst      (rst),
    .stop_req (stop_req),
    .run_en   (run_en),
    .run_cnt  (run_cnt),
    .gate_q   (gate_q),
    .tristate (tristate),
    .clk_oe   (clk_oe)
);

// File: tb/clk_stop_gate_bench.sv
`timescale 1ns/1ps
module clk_stop_gate_bench;
    localparam int           N     = 4;
    localparam int           SYNC  = 2;
    localparam int           MINR  = 100;
    localparam logic [N-1:0] FREEM = 4'b1000;

    logic         clk = 1'b0;
    logic         rst;
    logic         stop_n;
    logic [N-1:0] en_mask;
    logic         tristate;
    logic [N-1:0] clk_out;
    logic [N-1:0] clk_oe;

    int n_checks = 0;
    int n_fail   = 0;
    string tag   = "R1";

    always #4 clk = ~clk;

    clk_stop_gate #(.N_OUT(N), .SYNC_STAGES(SYNC), .MIN_RUN(MINR), .FREE_MASK(FREEM)) u_clk_stop_gate (
        .clk_src (clk),
        .rst     (rst),
        .stop_n  (stop_n),
        .en_mask (en_mask),
        .tristate(tristate),
        .clk_out (clk_out),
        .clk_oe  (clk_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit           syncq[$];
    bit           m_run;
    int           m_cnt;
    bit [N-1:0]   g_exp;
    bit           g_valid = 0;
    bit           r_rst, r_stop, r_tri;
    bit [N-1:0]   r_en;

    always @(negedge clk) begin
        #2;
        if (g_valid) check("R3", int'(clk_out), 0);
        r_rst  = rst;
        r_stop = stop_n;
        r_tri  = tristate;
        r_en   = en_mask;
        for (int i = 0; i < N; i++)
            g_exp[i] = !r_rst && r_en[i] && (FREEM[i] || m_run);
        g_valid = 1;
    end

    always @(posedge clk) begin
        #2;
        if (g_valid) begin
            bit oe_exp;
            bit req;
            check(tag, int'(clk_out), int'(g_exp));
            oe_exp = r_rst ? 1'b0 : !r_tri;
            check(r_rst ? "R1" : "R8", int'(clk_oe), oe_exp ? int'({N{1'b1}}) : 0);
            if (r_rst) begin
                syncq = {};
                for (int k = 0; k < SYNC; k++) syncq.push_back(1'b1);
                m_run = 1;
                m_cnt = 0;
            end else begin
                req = (syncq[0] == 1'b0);
                if (m_run) begin
                    if (req && m_cnt >= MINR - 1) m_run = 0;
                    else if (m_cnt < MINR - 1)    m_cnt++;
                end else if (!req) begin
                    m_run = 1;
                    m_cnt = 0;
                end
                void'(syncq.pop_front());
                syncq.push_back(r_stop);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic count_pulses(input int edges, input int idx, output int cnt);
        cnt = 0;
        for (int k = 0; k < edges; k++) begin
            @(posedge clk); #2;
            if (clk_out[idx]) cnt++;
        end
    endtask

    task automatic step_edge();
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1: actual hung run, expected completion");
        finish_run();
    end

    initial begin
        int c0, c1, c2, c3;
        int first;
        rst = 1'b1; stop_n = 1'b1; en_mask = '1; tristate = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset clk_out", int'(clk_out), 0);
        check("R1 reset clk_oe", int'(clk_oe), 0);

        // R5: request present from reset release is held for the run window
        tag = "R5";
        step_edge();
        rst = 1'b0; stop_n = 1'b0;
        count_pulses(200, 0, c0);
        check("R5 pulses before pending stop", c0, MINR);

        // R4: restart latency and full first pulse
        tag = "R4";
        step_edge();
        stop_n = 1'b1;
        first = 0;
        for (int k = 1; k <= 20 && first == 0; k++) begin
            @(posedge clk); #2;
            if (clk_out[0]) begin
                first = k;
                #1.5;
                check("R4 first pulse still high late in phase", int'(clk_out[0]), 1);
            end
        end
        check("R4 restart latency in edges", first, SYNC + 2);
        count_pulses(150, 0, c0);
        check("R4 running pulses", c0, 150);

        // R2 / R6: stop latency, free lane unaffected
        tag = "R2 R6";
        step_edge();
        stop_n = 1'b0;
        fork
            count_pulses(20, 0, c0);
            count_pulses(20, 3, c3);
        join
        check("R2 pulses after stop request", c0, SYNC + 1);
        check("R2 stop latency below four", int'(c0 < 4), 1);
        check("R6 free lane pulses", c3, 20);

        // R9: one-cycle release restarts a fresh window
        tag = "R9";
        step_edge();
        stop_n = 1'b1;
        step_edge();
        stop_n = 1'b0;
        count_pulses(300, 0, c0);
        check("R9 fresh window pulses", c0, MINR);

        // R7: enable mask
        tag = "R7";
        step_edge();
        stop_n = 1'b1;
        repeat (10) @(posedge clk);
        step_edge();
        en_mask = 4'b0101;
        fork
            count_pulses(20, 0, c0);
            count_pulses(20, 1, c1);
            count_pulses(20, 2, c2);
            count_pulses(20, 3, c3);
        join
        check("R7 enabled lane 0", c0, 20);
        check("R7 disabled lane 1", c1, 0);
        check("R7 enabled lane 2", c2, 20);
        check("R7 disabled free lane 3", c3, 0);
        step_edge();
        en_mask = '1;

        // R8: tristate
        tag = "R8";
        step_edge();
        tristate = 1'b1;
        @(posedge clk); #2;
        check("R8 oe low after tristate", int'(clk_oe), 0);
        count_pulses(5, 0, c0);
        check("R8 clocks unaffected", c0, 5);
        step_edge();
        tristate = 1'b0;
        @(posedge clk); #2;
        check("R8 oe restored", int'(clk_oe), int'({N{1'b1}}));

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule